// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block guards the bus writes that start a flash operation: program, page erase, mass erase or verify. Software first checks that the buffer-empty flag is high. It then makes three writes in a fixed order. The first is a 32-bit store into the flash array space, and the block keeps both its address and its data. The second writes an operation code to the command register. The third writes a 1 to the launch bit of the status register. Any other write between these steps ends the sequence: the access-error flag goes high and nothing starts.

Once a command is launched, the block shows it to an execution engine on a valid/ready output. Valid stays high, and code, address and data stay unchanged, until the engine takes the command with ready. Back-pressure only stretches this hold; no command is lost or repeated. The block then waits for a one-cycle done pulse from the engine, after which the buffer-empty and complete flags rise again.

How the latched address and data are passed on depends on the operation. Program passes both unchanged. Page erase clears the in-page address bits and sends zero data. Mass erase and verify send zero for both. No command launches until the flash clock divider register has been written at least once since reset.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cbeif=1, ccif=1, accerr=0, divld=0 and cmd_valid=0.
- R2: A write to register select 0 (wr_is_array=0, wr_addr[3:2]=0) sets divld and shows wr_data[DIV_W-1:0] on div_cfg from the next cycle.
- R3: An array write, then a write of a known code to register select 1, then a write with wr_data bit 7 set to register select 2 make cmd_valid=1, cbeif=0 and ccif=0 in the cycle after the third write.
- R4: Operation codes are 0x20 program (address and data passed unchanged), 0x40 page erase (address bits [PAGE_LSB-1:0] forced to 0, data 0), and 0x41 mass erase and 0x05 verify (address 0, data 0).
- R5: While cmd_valid=1 and cmd_ready=0, cmd_valid stays high and cmd_code, cmd_addr and cmd_data hold their values. The cycle after cmd_valid and cmd_ready are both high, cmd_valid is 0.
- R6: An eng_done pulse after the command is taken sets cbeif=1 and ccif=1 in the next cycle.
- R7: Any write other than the expected next step aborts an open sequence. accerr=1 from the next cycle, cmd_valid stays 0, and a launch write that follows launches nothing.
- R8: A command write whose code is not one of the four in R4 sets accerr and launches nothing.
- R9: If divld=0, the launch write sets accerr and launches nothing; cbeif stays 1.
- R10: accerr is cleared only by a status write with wr_data bit 5 set. A status write with bit 5 clear leaves it set.
- R11: While a command is outstanding (cbeif=0), an array, command or divider write sets accerr and does not change the command payload or cmd_valid.
- R12: A launch write when no sequence is open sets accerr and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_is_array | input | 1 | 1 = write targets the flash array space, 0 = register space |
| wr_addr | input | ADDR_W | Byte address; bits [3:2] pick the register in register space |
| wr_data | input | 32 | Write data |
| cbeif | output | 1 | Buffers empty, a new sequence may begin |
| ccif | output | 1 | No command outstanding |
| accerr | output | 1 | Access error, sticky |
| divld | output | 1 | Divider register written since reset |
| div_cfg | output | DIV_W | Divider value for the engine |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_code | output | 8 | Operation code |
| cmd_addr | output | ADDR_W | Address after operation masking |
| cmd_data | output | 32 | Data after operation masking |
| eng_done | input | 1 | One-cycle pulse when the engine finishes |

## Verification
If the sequencer ends up in the wrong step, the fault shows at the ports one cycle after the next bus write. A write that should have advanced the sequence raises accerr instead, or a launch write fails to raise cmd_valid. A corrupted operation buffer shows up as a wrong cmd_addr or cmd_data in the first cycle that cmd_valid is high. A missed busy state shows up as cbeif rising without a done pulse from the engine, or as cmd_valid dropping before the engine accepts. The directed cases pair each abort with a later launch attempt, so a sequence that is left open by mistake is caught within a few cycles.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ADDR   = 3'd1,
    S_CMD    = 3'd2,
    S_LAUNCH = 3'd3,
    S_BUSY   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_CMD  = 2'd1,
    REG_STAT = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OP_PROGRAM    = 8'h20;
  localparam logic [7:0] OP_PAGE_ERASE = 8'h40;
  localparam logic [7:0] OP_MASS_ERASE = 8'h41;
  localparam logic [7:0] OP_VERIFY     = 8'h05;

  localparam int STAT_LAUNCH_BIT = 7;
  localparam int STAT_ERR_BIT    = 5;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_PROGRAM) || (op == OP_PAGE_ERASE) ||
           (op == OP_MASS_ERASE) || (op == OP_VERIFY);
  endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
  import flash_seq_pkg::*;
(
  input  logic        wr_en,
  input  logic        wr_is_array,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] wr_data,
  output logic        acc_array,
  output logic        acc_div,
  output logic        acc_cmd,
  output logic        acc_stat,
  output logic        acc_rsvd,
  output logic        launch_bit,
  output logic        errclr_bit,
  output logic        op_ok
);
  reg_sel_e sel;

  always_comb begin
    sel       = reg_sel_e'(reg_sel);
    acc_array = wr_en && wr_is_array;
    acc_div   = wr_en && !wr_is_array && (sel == REG_DIV);
    acc_cmd   = wr_en && !wr_is_array && (sel == REG_CMD);
    acc_stat  = wr_en && !wr_is_array && (sel == REG_STAT);
    acc_rsvd  = wr_en && !wr_is_array && (sel == REG_RSVD);
    launch_bit = wr_data[STAT_LAUNCH_BIT];
    errclr_bit = wr_data[STAT_ERR_BIT];
    op_ok      = op_known(wr_data[7:0]);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_array,
  input  logic              acc_div,
  input  logic              acc_cmd,
  input  logic              acc_stat,
  input  logic              acc_rsvd,
  input  logic              launch_bit,
  input  logic              errclr_bit,
  input  logic              op_ok,
  input  logic              divld,
  input  logic              cmd_ready,
  input  logic              eng_done,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cbeif,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        op_q,
  output logic              err_set,
  output logic              err_clr,
  output logic              launch_go,
  output logic              done_go,
  output logic              div_wr
);
  seq_state_e state, nxt;
  logic ld_addr, ld_op, wr_any;

  assign wr_any = acc_array | acc_div | acc_cmd | acc_stat | acc_rsvd;

  always_comb begin
    nxt       = state;
    ld_addr   = 1'b0;
    ld_op     = 1'b0;
    err_set   = 1'b0;
    err_clr   = 1'b0;
    launch_go = 1'b0;
    done_go   = 1'b0;
    div_wr    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (acc_array) begin
          ld_addr = 1'b1;
          nxt     = S_ADDR;
        end else if (acc_cmd) begin
          err_set = 1'b1;
        end else if (acc_stat) begin
          err_set = launch_bit;
          err_clr = errclr_bit;
        end else if (acc_div) begin
          div_wr = 1'b1;
        end
      end
      S_ADDR: begin
        if (acc_cmd && op_ok) begin
          ld_op = 1'b1;
          nxt   = S_CMD;
        end else if (wr_any) begin
          err_set = 1'b1;
          nxt     = S_IDLE;
        end
      end
      S_CMD: begin
        if (acc_stat && launch_bit && divld) begin
          launch_go = 1'b1;
          nxt       = S_LAUNCH;
        end else if (wr_any) begin
          err_set = 1'b1;
          nxt     = S_IDLE;
        end
      end
      S_LAUNCH, S_BUSY: begin
        err_set = acc_array | acc_cmd | acc_div;
        err_clr = acc_stat & errclr_bit;
        if (state == S_LAUNCH) begin
          if (cmd_ready) nxt = S_BUSY;
        end else if (eng_done) begin
          done_go = 1'b1;
          nxt     = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      op_q   <= '0;
    end else begin
      state <= nxt;
      if (ld_addr) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
      if (ld_op) op_q <= wr_data[7:0];
    end
  end

  assign cbeif     = (state == S_IDLE) || (state == S_ADDR) || (state == S_CMD);
  assign cmd_valid = (state == S_LAUNCH);
endmodule

// File: rtl/flash_stat_regs.sv
module flash_stat_regs #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_set,
  input  logic             err_clr,
  input  logic             launch_go,
  input  logic             done_go,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic             accerr,
  output logic             ccif,
  output logic             divld,
  output logic [DIV_W-1:0] div_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accerr  <= 1'b0;
      ccif    <= 1'b1;
      divld   <= 1'b0;
      div_cfg <= '0;
    end else begin
      if (err_set)      accerr <= 1'b1;
      else if (err_clr) accerr <= 1'b0;
      if (launch_go)    ccif <= 1'b0;
      else if (done_go) ccif <= 1'b1;
      if (div_wr) begin
        divld   <= 1'b1;
        div_cfg <= div_val;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_payload.sv
module flash_cmd_payload
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 10
) (
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_LSB;

  always_comb begin
    addr_out = '0;
    data_out = '0;
    if (op == OP_PROGRAM) begin
      addr_out = addr_in;
      data_out = data_in;
    end else if (op == OP_PAGE_ERASE) begin
      addr_out = addr_in & PAGE_MASK;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 19,
  parameter int DIV_W    = 7,
  parameter int PAGE_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_array,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              cbeif,
  output logic              ccif,
  output logic              accerr,
  output logic              divld,
  output logic [DIV_W-1:0]  div_cfg,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [31:0]       cmd_data,
  input  logic              eng_done
);
  localparam int DATA_W = 32;

  logic acc_array, acc_div, acc_cmd, acc_stat, acc_rsvd;
  logic launch_bit, errclr_bit, op_ok;
  logic err_set, err_clr, launch_go, done_go, div_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [7:0]        op_q;

  flash_bus_decode u_dec (
    .wr_en      (wr_en),
    .wr_is_array(wr_is_array),
    .reg_sel    (wr_addr[3:2]),
    .wr_data    (wr_data),
    .acc_array  (acc_array),
    .acc_div    (acc_div),
    .acc_cmd    (acc_cmd),
    .acc_stat   (acc_stat),
    .acc_rsvd   (acc_rsvd),
    .launch_bit (launch_bit),
    .errclr_bit (errclr_bit),
    .op_ok      (op_ok)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_array (acc_array),
    .acc_div   (acc_div),
    .acc_cmd   (acc_cmd),
    .acc_stat  (acc_stat),
    .acc_rsvd  (acc_rsvd),
    .launch_bit(launch_bit),
    .errclr_bit(errclr_bit),
    .op_ok     (op_ok),
    .divld     (divld),
    .cmd_ready (cmd_ready),
    .eng_done  (eng_done),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cbeif     (cbeif),
    .cmd_valid (cmd_valid),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .op_q      (op_q),
    .err_set   (err_set),
    .err_clr   (err_clr),
    .launch_go (launch_go),
    .done_go   (done_go),
    .div_wr    (div_wr)
  );

  flash_stat_regs #(.DIV_W(DIV_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_set  (err_set),
    .err_clr  (err_clr),
    .launch_go(launch_go),
    .done_go  (done_go),
    .div_wr   (div_wr),
    .div_val  (wr_data[DIV_W-1:0]),
    .accerr   (accerr),
    .ccif     (ccif),
    .divld    (divld),
    .div_cfg  (div_cfg)
  );

  flash_cmd_payload #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB)) u_pay (
    .op      (op_q),
    .addr_in (addr_q),
    .data_in (data_q),
    .addr_out(cmd_addr),
    .data_out(cmd_data)
  );

  assign cmd_code = op_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DIV_W    = 7,
  parameter int PAGE_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_is_array,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              cbeif,
  input logic              ccif,
  input logic              accerr,
  input logic              divld,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [31:0]       cmd_data,
  input logic              eng_done
);
  p_busy_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!cbeif && !ccif));

  p_page_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_PAGE_ERASE) |-> (cmd_addr[PAGE_LSB-1:0] == '0 && cmd_data == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_data)));

  p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cbeif) |-> $past(eng_done));

  p_need_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> divld);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(accerr) |-> $past(wr_en && !wr_is_array && wr_addr[3:2] == 2'd2 && wr_data[STAT_ERR_BIT]));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PAGE_LSB(PAGE_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_array(wr_is_array),
  .wr_addr(wr_addr), .wr_data(wr_data), .cbeif(cbeif), .ccif(ccif),
  .accerr(accerr), .divld(divld), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .eng_done(eng_done)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int AW = 19;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_is_array = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cbeif, ccif, accerr, divld, cmd_valid;
  logic cmd_ready = 1'b0, eng_done = 1'b0;
  logic [DW-1:0] div_cfg;
  logic [7:0] cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [31:0] cmd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DIV_W(DW), .PAGE_LSB(10)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_array(wr_is_array),
    .wr_addr(wr_addr), .wr_data(wr_data), .cbeif(cbeif), .ccif(ccif),
    .accerr(accerr), .divld(divld), .div_cfg(div_cfg), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .eng_done(eng_done)
  );

  typedef struct packed {
    logic [7:0]    op;
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [AW-1:0] ea;
    logic [31:0]   ed;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'h20, 19'h12345, 32'hDEADBEEF, 19'h12345, 32'hDEADBEEF},
    '{8'h40, 19'h7ABCD, 32'h11111111, 19'h7A800, 32'h0},
    '{8'h41, 19'h00F0F, 32'h22222222, 19'h0,     32'h0},
    '{8'h05, 19'h3C3C3, 32'h33333333, 19'h0,     32'h0},
    '{8'h20, 19'h7FFFF, 32'h00000000, 19'h7FFFF, 32'h0},
    '{8'h40, 19'h003FF, 32'hFFFFFFFF, 19'h0,     32'h0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_arr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_array = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_is_array = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_array = 1'b0; wr_addr = {15'h0, sel, 2'b00}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_cmd();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cbeif", 64'(cbeif), 64'd1);
    chk("R1", "ccif", 64'(ccif), 64'd1);
    chk("R1", "accerr", 64'(accerr), 64'd0);
    chk("R1", "divld", 64'(divld), 64'd0);
    chk("R1", "cmd_valid", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 launch before divider written
    wr_arr(19'h00100, 32'h5);
    wr_reg(2'd1, 32'h20);
    wr_reg(2'd2, 32'h80);
    chk("R9", "accerr", 64'(accerr), 64'd1);
    chk("R9", "cmd_valid", 64'(cmd_valid), 64'd0);
    chk("R9", "cbeif", 64'(cbeif), 64'd1);

    // R10 clear needs bit 5 set
    wr_reg(2'd2, 32'h0);
    chk("R10", "accerr kept", 64'(accerr), 64'd1);
    wr_reg(2'd2, 32'h20);
    chk("R10", "accerr cleared", 64'(accerr), 64'd0);

    // R2 divider write
    wr_reg(2'd0, 32'h54);
    chk("R2", "divld", 64'(divld), 64'd1);
    chk("R2", "div_cfg", 64'(div_cfg), 64'h54);

    // Table walk: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      wr_arr(VECS[i].a, VECS[i].d);
      wr_reg(2'd1, 32'(VECS[i].op));
      wr_reg(2'd2, 32'h80);
      chk("R3", "cmd_valid", 64'(cmd_valid), 64'd1);
      chk("R3", "cbeif", 64'(cbeif), 64'd0);
      chk("R3", "ccif", 64'(ccif), 64'd0);
      chk("R4", "cmd_code", 64'(cmd_code), 64'(VECS[i].op));
      chk("R4", "cmd_addr", 64'(cmd_addr), 64'(VECS[i].ea));
      chk("R4", "cmd_data", 64'(cmd_data), 64'(VECS[i].ed));
      repeat (2) @(negedge clk);
      chk("R5", "valid held", 64'(cmd_valid), 64'd1);
      chk("R5", "addr held", 64'(cmd_addr), 64'(VECS[i].ea));
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk("R5", "valid dropped", 64'(cmd_valid), 64'd0);
      chk("R6", "cbeif still low", 64'(cbeif), 64'd0);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      chk("R6", "cbeif", 64'(cbeif), 64'd1);
      chk("R6", "ccif", 64'(ccif), 64'd1);
    end
    chk("R3", "no error after table", 64'(accerr), 64'd0);

    // R12 launch with nothing open
    wr_reg(2'd2, 32'h80);
    chk("R12", "accerr", 64'(accerr), 64'd1);
    chk("R12", "cmd_valid", 64'(cmd_valid), 64'd0);
    wr_reg(2'd2, 32'h20);

    // R7 intermediate array write, then launch attempt
    wr_arr(19'h00200, 32'h1);
    wr_arr(19'h00300, 32'h2);
    chk("R7", "accerr", 64'(accerr), 64'd1);
    wr_reg(2'd2, 32'h80);
    chk("R7", "no launch", 64'(cmd_valid), 64'd0);
    wr_reg(2'd2, 32'h20);
    // R7 abort between command and launch
    wr_arr(19'h00200, 32'h1);
    wr_reg(2'd1, 32'h20);
    wr_reg(2'd0, 32'h54);
    chk("R7", "accerr step3", 64'(accerr), 64'd1);
    chk("R7", "no launch step3", 64'(cmd_valid), 64'd0);
    wr_reg(2'd2, 32'h20);

    // R8 unknown code
    wr_arr(19'h00400, 32'h3);
    wr_reg(2'd1, 32'h77);
    chk("R8", "accerr", 64'(accerr), 64'd1);
    wr_reg(2'd2, 32'h80);
    chk("R8", "no launch", 64'(cmd_valid), 64'd0);
    wr_reg(2'd2, 32'h20);

    // R11 writes while outstanding
    wr_arr(19'h01234, 32'hCAFEF00D);
    wr_reg(2'd1, 32'h20);
    wr_reg(2'd2, 32'h80);
    wr_arr(19'h05555, 32'h0BADBAD0);
    chk("R11", "accerr", 64'(accerr), 64'd1);
    chk("R11", "cmd_valid", 64'(cmd_valid), 64'd1);
    chk("R11", "cmd_addr", 64'(cmd_addr), 64'h01234);
    chk("R11", "cmd_data", 64'(cmd_data), 64'hCAFEF00D);
    wr_reg(2'd1, 32'h41);
    chk("R11", "cmd_code", 64'(cmd_code), 64'h20);
    finish_cmd();
    chk("R11", "completed", 64'(cbeif), 64'd1);
    wr_reg(2'd2, 32'h20);
    chk("R10", "final clear", 64'(accerr), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule